// File: doc/BRIEF.md
# Single-Precision Operand Prescreen

This block sits in front of a single-precision add, subtract, multiply or divide unit and conditions its two operands before any arithmetic happens. Each operand is sorted into one of six kinds: zero, denormal, normal, infinity, quiet NaN or signaling NaN. When the flush-denormal-inputs mode is on, denormal operands are swapped for zeros that keep their sign.

From the conditioned operands the block finds the faults that can be known before computing: invalid operation, denormal operand and divide-by-zero. It compares them with a 6-bit mask and decides whether a trap must be raised and with which cause. When nothing is raised but the result is already known to be a NaN, it supplies that NaN so the arithmetic unit can skip the computation.

Results leave through a one-deep registered stage with a valid/ready handshake. Conditioned operands, flags, cause and default result stay aligned in that register. Result-based conditions (overflow, underflow, inexact) belong to later stages and are only looked at when this stage raises nothing.

Top module: `fp_operand_screen`

## Requirements
- R1: `inReady` equals `!outValid || outReady`. An operand pair accepted on a clock edge (`inValid && inReady`) appears on the outputs with `outValid` high after that edge. While `outValid` is high and `outReady` is low, every output holds its value.
- R2: With `dazEn` = 1, a denormal operand (exponent field 0, fraction nonzero) leaves as a zero of the same sign (0x00000000 or 0x80000000), and status bit 1 (denormal) is not set on its account.
- R3: With `dazEn` = 0, denormal operands pass unchanged and set status bit 1. Operands that are not denormal always pass unchanged.
- R4: `statusFlags` and `excMask` share one bit order: bit 0 invalid, bit 1 denormal, bit 2 divide-by-zero, bit 3 overflow, bit 4 underflow, bit 5 precision. A mask bit of 1 means masked. This block never sets bits 5:3.
- R5: Status bit 0 is set in four cases, using conditioned operands. (1) Either operand is a signaling NaN: exponent all ones, fraction nonzero, fraction bit 22 = 0. (2) With no NaN present, both operands are infinite in an effective subtraction: `opSel` 0 (add) with differing signs, or `opSel` 1 (subtract) with equal signs. (3) With no NaN present, zero times infinity in either order under `opSel` 2. (4) With no NaN present, 0/0 or Inf/Inf under `opSel` 3.
- R6: Status bit 2 is set when `opSel` is 3 (divide), the conditioned divisor is zero, and the dividend is finite and nonzero (normal, or denormal that was not flushed).
- R7: `raiseFault` is 1 exactly when some set status bit has its mask bit at 0. `faultCause` names the highest-priority unmasked fault: 1 invalid, then 2 denormal, then 3 divide-by-zero. It is 0 when nothing is raised.
- R8: `defaultValid` is 1 when nothing is raised and either status bit 0 is set or an operand is a NaN. `defaultResult` is then the first NaN operand with bit 22 forced to 1 (operand A before operand B), or 0xFFC00000 when neither operand is a NaN.
- R9: During and right after reset, `outValid` is 0, `statusFlags` is 0 and `inReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operand pair offered |
| inReady | output | 1 | Stage can accept a pair |
| opA | input | 32 | First operand, single precision |
| opB | input | 32 | Second operand, single precision |
| opSel | input | 2 | 0 add, 1 subtract, 2 multiply, 3 divide |
| dazEn | input | 1 | Flush denormal inputs to signed zero |
| excMask | input | 6 | Fault mask, 1 = masked, order as in R4 |
| outValid | output | 1 | Output register holds a screened pair |
| outReady | input | 1 | Consumer takes the pair |
| condA | output | 32 | Conditioned first operand |
| condB | output | 32 | Conditioned second operand |
| statusFlags | output | 6 | Detected faults, order as in R4 |
| raiseFault | output | 1 | An unmasked fault must trap |
| faultCause | output | 2 | 0 none, 1 invalid, 2 denormal, 3 divide-by-zero |
| defaultValid | output | 1 | Result is already known to be a NaN |
| defaultResult | output | 32 | That NaN result |

## Verification
The hardest case to reach from the ports is several faults meeting in one pair. Examples are a signaling NaN next to a denormal, or a denormal dividend over a zero divisor. In those cases the cause priority and the per-bit masking decide the outcome. Fully random 32-bit operands almost never hit these special kinds, so the stimulus draws each operand from a pool weighted toward zeros, denormals, infinities and both NaN kinds. It then applies random masks, flush modes and back-pressure on top of a directed list of collisions.

// File: rtl/fp_screen_pkg.sv
package fp_screen_pkg;
  localparam int EXP_BITS  = 8;
  localparam int FRAC_BITS = 23;
  localparam int FLAG_BITS = 6;
  // fixed status/mask positions
  localparam int BIT_INV = 0;
  localparam int BIT_DEN = 1;
  localparam int BIT_DZ  = 2;

  typedef enum logic [2:0] {
    K_ZERO, K_DENORM, K_NORMAL, K_INF, K_QNAN, K_SNAN
  } opKind_e;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0, OP_SUB = 2'd1, OP_MUL = 2'd2, OP_DIV = 2'd3
  } arithOp_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0, CAUSE_INV = 2'd1, CAUSE_DEN = 2'd2, CAUSE_DZ = 2'd3
  } cause_e;

  // control -> datapath strobes
  typedef struct packed {
    logic load;
    logic nanFromA;
    logic nanFromB;
  } screenStrobe_t;

  // datapath -> control operand summary
  typedef struct packed {
    opKind_e kindA;
    opKind_e kindB;
    logic    signA;
    logic    signB;
  } kindPair_t;
endpackage

// File: rtl/fp_screen_classify.sv
module fp_screen_classify
  import fp_screen_pkg::*;
#(
  parameter int EXP_W  = EXP_BITS,
  parameter int FRAC_W = FRAC_BITS
) (
  input  logic [EXP_W+FRAC_W:0] operand,
  input  logic                  dazEn,
  output opKind_e               kind,
  output logic [EXP_W+FRAC_W:0] conditioned
);
  localparam int DATA_W = 1 + EXP_W + FRAC_W;

  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;
  logic              expOnes, expZeros, fracZero, flushIt;
  opKind_e           rawKind;

  assign expField  = operand[FRAC_W +: EXP_W];
  assign fracField = operand[FRAC_W-1:0];
  assign expOnes   = &expField;
  assign expZeros  = ~|expField;
  assign fracZero  = ~|fracField;

  always_comb begin
    if (expOnes) begin
      if (fracZero)                   rawKind = K_INF;
      else if (fracField[FRAC_W-1])   rawKind = K_QNAN;
      else                            rawKind = K_SNAN;
    end else if (expZeros) begin
      rawKind = fracZero ? K_ZERO : K_DENORM;
    end else begin
      rawKind = K_NORMAL;
    end
  end

  assign flushIt     = dazEn && (rawKind == K_DENORM);
  assign kind        = flushIt ? K_ZERO : rawKind;
  assign conditioned = flushIt ? {operand[DATA_W-1], {(DATA_W-1){1'b0}}} : operand;
endmodule

// File: rtl/fp_screen_datapath.sv
module fp_screen_datapath
  import fp_screen_pkg::*;
#(
  parameter int EXP_W  = EXP_BITS,
  parameter int FRAC_W = FRAC_BITS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  input  logic                  dazEn,
  input  screenStrobe_t         strobeIn,
  output kindPair_t             kinds,
  output logic [EXP_W+FRAC_W:0] condA,
  output logic [EXP_W+FRAC_W:0] condB,
  output logic [EXP_W+FRAC_W:0] defaultResult
);
  localparam int DATA_W   = 1 + EXP_W + FRAC_W;
  localparam int NUM_OPS  = 2;
  localparam logic [DATA_W-1:0] QUIET_BIT =
    {{(DATA_W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] CANON_NAN =
    {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [DATA_W-1:0] rawOp  [NUM_OPS];
  logic [DATA_W-1:0] condOp [NUM_OPS];
  opKind_e           kindOp [NUM_OPS];
  logic [DATA_W-1:0] nanPick;

  assign rawOp[0] = opA;
  assign rawOp[1] = opB;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_lane
    fp_screen_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_classify (
      .operand    (rawOp[g]),
      .dazEn      (dazEn),
      .kind       (kindOp[g]),
      .conditioned(condOp[g])
    );
  end

  assign kinds.kindA = kindOp[0];
  assign kinds.kindB = kindOp[1];
  assign kinds.signA = opA[DATA_W-1];
  assign kinds.signB = opB[DATA_W-1];

  always_comb begin
    if (strobeIn.nanFromA)      nanPick = rawOp[0] | QUIET_BIT;
    else if (strobeIn.nanFromB) nanPick = rawOp[1] | QUIET_BIT;
    else                        nanPick = CANON_NAN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      condA         <= '0;
      condB         <= '0;
      defaultResult <= '0;
    end else if (strobeIn.load) begin
      condA         <= condOp[0];
      condB         <= condOp[1];
      defaultResult <= nanPick;
    end
  end

  // R2
  daz_flush_chk: assert property (@(posedge clk) disable iff (rst)
    strobeIn.load && dazEn |=>
      ((condA[FRAC_W +: EXP_W] != '0) || (condA[FRAC_W-1:0] == '0)) &&
      ((condB[FRAC_W +: EXP_W] != '0) || (condB[FRAC_W-1:0] == '0)));

  // R8
  quiet_nan_chk: assert property (@(posedge clk) disable iff (rst)
    strobeIn.load |=> defaultResult[FRAC_W-1] && (&defaultResult[FRAC_W +: EXP_W]));
endmodule

// File: rtl/fp_screen_control.sv
module fp_screen_control
  import fp_screen_pkg::*;
#(
  parameter int FLAG_W = FLAG_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic              outReady,
  output logic              outValid,
  input  logic [1:0]        opSel,
  input  logic [FLAG_W-1:0] excMask,
  input  kindPair_t         kinds,
  output screenStrobe_t     strobeOut,
  output logic [FLAG_W-1:0] statusFlags,
  output logic              raiseFault,
  output logic [1:0]        faultCause,
  output logic              defaultValid
);
  logic isZeroA, isZeroB, isInfA, isInfB, isNanA, isNanB, anySnan, anyNan;
  logic finiteNzA, effSub, invCond, denCond, dzCond;
  logic [FLAG_W-1:0] flagsNext, unmasked;
  logic   raiseNext, defaultNext;
  cause_e causeNext;
  arithOp_e op;

  assign op        = arithOp_e'(opSel);
  assign isZeroA   = kinds.kindA == K_ZERO;
  assign isZeroB   = kinds.kindB == K_ZERO;
  assign isInfA    = kinds.kindA == K_INF;
  assign isInfB    = kinds.kindB == K_INF;
  assign isNanA    = (kinds.kindA == K_QNAN) || (kinds.kindA == K_SNAN);
  assign isNanB    = (kinds.kindB == K_QNAN) || (kinds.kindB == K_SNAN);
  assign anySnan   = (kinds.kindA == K_SNAN) || (kinds.kindB == K_SNAN);
  assign anyNan    = isNanA || isNanB;
  assign finiteNzA = (kinds.kindA == K_NORMAL) || (kinds.kindA == K_DENORM);
  assign effSub    = ((op == OP_ADD) && (kinds.signA != kinds.signB)) ||
                     ((op == OP_SUB) && (kinds.signA == kinds.signB));

  always_comb begin
    invCond = anySnan;
    if (!anyNan) begin
      unique case (op)
        OP_ADD, OP_SUB: if (isInfA && isInfB && effSub) invCond = 1'b1;
        OP_MUL:         if ((isZeroA && isInfB) || (isInfA && isZeroB)) invCond = 1'b1;
        OP_DIV:         if ((isZeroA && isZeroB) || (isInfA && isInfB)) invCond = 1'b1;
        default:        invCond = anySnan;
      endcase
    end
  end

  assign denCond = (kinds.kindA == K_DENORM) || (kinds.kindB == K_DENORM);
  assign dzCond  = (op == OP_DIV) && isZeroB && finiteNzA;

  always_comb begin
    flagsNext          = '0;
    flagsNext[BIT_INV] = invCond;
    flagsNext[BIT_DEN] = denCond;
    flagsNext[BIT_DZ]  = dzCond;
  end

  assign unmasked  = flagsNext & ~excMask;
  assign raiseNext = |unmasked;

  always_comb begin
    if (unmasked[BIT_INV])      causeNext = CAUSE_INV;
    else if (unmasked[BIT_DEN]) causeNext = CAUSE_DEN;
    else if (unmasked[BIT_DZ])  causeNext = CAUSE_DZ;
    else                        causeNext = CAUSE_NONE;
  end

  assign defaultNext = !raiseNext && (invCond || anyNan);

  assign inReady            = !outValid || outReady;
  assign strobeOut.load     = inValid && inReady;
  assign strobeOut.nanFromA = isNanA;
  assign strobeOut.nanFromB = !isNanA && isNanB;

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid     <= 1'b0;
      statusFlags  <= '0;
      raiseFault   <= 1'b0;
      faultCause   <= CAUSE_NONE;
      defaultValid <= 1'b0;
    end else begin
      if (strobeOut.load) begin
        outValid     <= 1'b1;
        statusFlags  <= flagsNext;
        raiseFault   <= raiseNext;
        faultCause   <= causeNext;
        defaultValid <= defaultNext;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
    end
  end

  // R1
  hold_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(statusFlags) &&
      $stable(raiseFault) && $stable(faultCause) && $stable(defaultValid));

  // R4
  upper_flags_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> statusFlags[FLAG_W-1:BIT_DZ+1] == '0);

  // R7
  raise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (raiseFault == (faultCause != CAUSE_NONE)));

  // R8
  no_default_on_raise_chk: assert property (@(posedge clk) disable iff (rst)
    outValid && raiseFault |-> !defaultValid);
endmodule

// File: rtl/fp_operand_screen.sv
module fp_operand_screen
  import fp_screen_pkg::*;
#(
  parameter int EXP_W  = EXP_BITS,
  parameter int FRAC_W = FRAC_BITS,
  parameter int FLAG_W = FLAG_BITS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  inValid,
  output logic                  inReady,
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  input  logic [1:0]            opSel,
  input  logic                  dazEn,
  input  logic [FLAG_W-1:0]     excMask,
  output logic                  outValid,
  input  logic                  outReady,
  output logic [EXP_W+FRAC_W:0] condA,
  output logic [EXP_W+FRAC_W:0] condB,
  output logic [FLAG_W-1:0]     statusFlags,
  output logic                  raiseFault,
  output logic [1:0]            faultCause,
  output logic                  defaultValid,
  output logic [EXP_W+FRAC_W:0] defaultResult
);
  screenStrobe_t strobe;
  kindPair_t     kinds;

  fp_screen_datapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_datapath (
    .clk          (clk),
    .rst          (rst),
    .opA          (opA),
    .opB          (opB),
    .dazEn        (dazEn),
    .strobeIn     (strobe),
    .kinds        (kinds),
    .condA        (condA),
    .condB        (condB),
    .defaultResult(defaultResult)
  );

  fp_screen_control #(.FLAG_W(FLAG_W)) i_control (
    .clk         (clk),
    .rst         (rst),
    .inValid     (inValid),
    .inReady     (inReady),
    .outReady    (outReady),
    .outValid    (outValid),
    .opSel       (opSel),
    .excMask     (excMask),
    .kinds       (kinds),
    .strobeOut   (strobe),
    .statusFlags (statusFlags),
    .raiseFault  (raiseFault),
    .faultCause  (faultCause),
    .defaultValid(defaultValid)
  );

  // R1
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> $stable(condA) && $stable(condB) && $stable(defaultResult));
endmodule

// File: tb/test_fp_operand_screen.sv
`timescale 1ns/1ps
module test_fp_operand_screen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0, outReady = 1'b0, dazEn = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [1:0]  opSel = '0;
  logic [5:0]  excMask = '0;
  logic        inReady, outValid, raiseFault, defaultValid;
  logic [31:0] condA, condB, defaultResult;
  logic [5:0]  statusFlags;
  logic [1:0]  faultCause;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fp_operand_screen i_fp_operand_screen (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .opA(opA), .opB(opB), .opSel(opSel), .dazEn(dazEn), .excMask(excMask),
    .outValid(outValid), .outReady(outReady), .condA(condA), .condB(condB),
    .statusFlags(statusFlags), .raiseFault(raiseFault), .faultCause(faultCause),
    .defaultValid(defaultValid), .defaultResult(defaultResult)
  );

  // ---------------- behavioural reference ----------------
  function automatic bit fIsDen(input logic [31:0] x);
    return ((x & 32'h7F800000) == 0) && ((x & 32'h007FFFFF) != 0);
  endfunction
  function automatic bit fIsZero(input logic [31:0] x);
    return (x & 32'h7FFFFFFF) == 0;
  endfunction
  function automatic bit fIsInf(input logic [31:0] x);
    return (x & 32'h7FFFFFFF) == 32'h7F800000;
  endfunction
  function automatic bit fIsNan(input logic [31:0] x);
    return (x & 32'h7FFFFFFF) > 32'h7F800000;
  endfunction
  function automatic bit fIsSnan(input logic [31:0] x);
    return fIsNan(x) && ((x & 32'h00400000) == 0);
  endfunction

  logic        mValid = 0;
  logic [31:0] mCa, mCb, mDr;
  logic [5:0]  mFl;
  logic        mRs, mDv;
  logic [1:0]  mCs;

  task automatic refModel(input logic [31:0] a, b, input logic [1:0] op,
                          input logic daz, input logic [5:0] m);
    logic [31:0] ca, cb;
    bit inv, den, dz, nanAny, sa, sb, effSub;
    logic [5:0] um;
    ca = (daz && fIsDen(a)) ? (a & 32'h80000000) : a;
    cb = (daz && fIsDen(b)) ? (b & 32'h80000000) : b;
    sa = a[31]; sb = b[31];
    nanAny = fIsNan(ca) || fIsNan(cb);
    effSub = (op == 0) ? (sa != sb) : (sa == sb);
    inv = fIsSnan(ca) || fIsSnan(cb);
    if (!nanAny) begin
      if (op <= 1 && fIsInf(ca) && fIsInf(cb) && effSub) inv = 1;
      if (op == 2 && ((fIsZero(ca) && fIsInf(cb)) || (fIsInf(ca) && fIsZero(cb)))) inv = 1;
      if (op == 3 && ((fIsZero(ca) && fIsZero(cb)) || (fIsInf(ca) && fIsInf(cb)))) inv = 1;
    end
    den = fIsDen(ca) || fIsDen(cb);
    dz  = (op == 3) && fIsZero(cb) && !fIsZero(ca) && !fIsInf(ca) && !fIsNan(ca);
    mFl = {3'b000, dz, den, inv};
    um  = mFl & ~m;
    mRs = um != 0;
    mCs = um[0] ? 2'd1 : um[1] ? 2'd2 : um[2] ? 2'd3 : 2'd0;
    mDv = !mRs && (inv || nanAny);
    mDr = fIsNan(a) ? (a | 32'h00400000) : fIsNan(b) ? (b | 32'h00400000) : 32'hFFC00000;
    mCa = ca; mCb = cb;
  endtask

  always @(posedge clk) begin
    if (rst) mValid = 0;
    else if (inValid && (!mValid || outReady)) begin
      refModel(opA, opB, opSel, dazEn, excMask);
      mValid = 1;
    end else if (outReady) mValid = 0;
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("R1 inReady", {31'd0, inReady}, {31'd0, !mValid || outReady});
    chk("R1 outValid", {31'd0, outValid}, {31'd0, mValid});
    if (mValid) begin
      chk("R2 R3 condA", condA, mCa);
      chk("R2 R3 condB", condB, mCb);
      chk("R4 R5 R6 statusFlags", {26'd0, statusFlags}, {26'd0, mFl});
      chk("R7 raiseFault", {31'd0, raiseFault}, {31'd0, mRs});
      chk("R7 faultCause", {30'd0, faultCause}, {30'd0, mCs});
      chk("R8 defaultValid", {31'd0, defaultValid}, {31'd0, mDv});
      if (mDv) chk("R8 defaultResult", defaultResult, mDr);
    end
  endtask

  task automatic step();
    @(negedge clk);
    compareAll();
  endtask

  task automatic apply(input logic [31:0] a, b, input logic [1:0] op,
                       input logic daz, input logic [5:0] m, input logic rdy);
    opA = a; opB = b; opSel = op; dazEn = daz; excMask = m;
    inValid = 1; outReady = rdy;
    step();
  endtask

  function automatic logic [31:0] pickOperand();
    logic [31:0] s;
    s = {$urandom_range(1, 0) == 1, 31'd0};
    case ($urandom_range(9, 0))
      0: return s;
      1: return s | 32'h7F800000;
      2: return s | 32'h7FC00000 | ($urandom & 32'h003FFFFF);
      3: return s | 32'h7F800000 | (($urandom & 32'h003FFFFF) | 32'd1);
      4, 5: return s | (($urandom & 32'h007FFFFF) | 32'd1);
      6: return s | 32'h7F7FFFFF;
      default: return s | ({1'b0, 8'($urandom_range(254, 1)), 23'd0}) | ($urandom & 32'h007FFFFF);
    endcase
  endfunction

  initial begin
    repeat (3) step();
    // R9 reset state
    chk("R9 outValid in reset", {31'd0, outValid}, 32'd0);
    chk("R9 statusFlags in reset", {26'd0, statusFlags}, 32'd0);
    rst = 0;
    step();
    chk("R9 inReady after reset", {31'd0, inReady}, 32'd1);

    // R2: flush negative denormal, no denormal flag
    apply(32'h80000123, 32'h3F800000, 2'd0, 1'b1, 6'h00, 1'b1);
    // R3: same pair without flush -> denormal fault, cause 2
    apply(32'h80000123, 32'h3F800000, 2'd0, 1'b0, 6'h00, 1'b1);
    // R5: +Inf + -Inf, +Inf - +Inf, 0*Inf, 0/0, Inf/Inf, sNaN
    apply(32'h7F800000, 32'hFF800000, 2'd0, 1'b0, 6'h3F, 1'b1);
    apply(32'h7F800000, 32'h7F800000, 2'd1, 1'b0, 6'h00, 1'b1);
    apply(32'h7F800000, 32'h7F800000, 2'd0, 1'b0, 6'h00, 1'b1);
    apply(32'h80000000, 32'h7F800000, 2'd2, 1'b0, 6'h3F, 1'b1);
    apply(32'h00000000, 32'h80000000, 2'd3, 1'b0, 6'h3F, 1'b1);
    apply(32'hFF800000, 32'h7F800000, 2'd3, 1'b0, 6'h00, 1'b1);
    apply(32'h3F800000, 32'h7F800001, 2'd2, 1'b0, 6'h00, 1'b1);
    // R5 with flushed zero: denormal * Inf under flush is invalid
    apply(32'h00000001, 32'hFF800000, 2'd2, 1'b1, 6'h3E, 1'b1);
    // R6: 1.0 / -0 masked and unmasked
    apply(32'h3F800000, 32'h80000000, 2'd3, 1'b0, 6'h3F, 1'b1);
    apply(32'h3F800000, 32'h80000000, 2'd3, 1'b0, 6'h00, 1'b1);
    // R8: masked sNaN A with qNaN B -> quieted A
    apply(32'hFF800001, 32'h7FC12345, 2'd0, 1'b0, 6'h3F, 1'b1);
    // R8: qNaN in B only
    apply(32'h3F800000, 32'h7FC12345, 2'd2, 1'b0, 6'h00, 1'b1);
    // R7 priority: sNaN with denormal -> invalid first
    apply(32'h7F800002, 32'h00000010, 2'd0, 1'b0, 6'h00, 1'b1);
    // R7: denormal over zero -> denormal then divide-by-zero when masked
    apply(32'h00000010, 32'h00000000, 2'd3, 1'b0, 6'h00, 1'b1);
    apply(32'h00000010, 32'h00000000, 2'd3, 1'b0, 6'h02, 1'b1);
    // R1 back-pressure: hold output while new pairs wait
    apply(32'h7F800000, 32'h00000000, 2'd2, 1'b0, 6'h00, 1'b0);
    apply(32'h00000000, 32'h00000000, 2'd3, 1'b0, 6'h00, 1'b0);
    apply(32'h3F800000, 32'h40000000, 2'd1, 1'b0, 6'h00, 1'b0);
    apply(32'h3F800000, 32'h40000000, 2'd1, 1'b0, 6'h00, 1'b1);
    inValid = 0;
    step();

    // random mix of special kinds, masks, modes and back-pressure
    for (int i = 0; i < 4000; i++) begin
      opA = pickOperand();
      opB = pickOperand();
      opSel = 2'($urandom_range(3, 0));
      dazEn = $urandom_range(1, 0) == 1;
      excMask = ($urandom_range(1, 0) == 1) ? 6'h3F : 6'($urandom);
      inValid = $urandom_range(4, 0) != 0;
      outReady = $urandom_range(3, 0) != 0;
      step();
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule